// File: doc/BRIEF.md
# Decimal Accumulator Processor

A small multi-cycle machine that runs programs written as three-digit decimal words. Each word of its 100-word internal store holds a value from 0 to 999. The hundreds digit of an instruction selects the operation, and the two low digits name a memory address. Three whole-word codes are reserved: one halts the machine, one reads a value from the input port, and one sends the accumulator to the output port. The datapath is built from an accumulator, a negative flag, a program counter, a memory address register, a memory data register and an instruction register.

Every instruction passes through five states: address fetch, data fetch, decode, execute and writeback. An input instruction waits in execute until a value is offered. Results wrap modulo 1000. A separate negative flag records whether the last subtraction borrowed, and the conditional branch on zero-or-positive tests that flag.

The program store is loaded through a write port that is honoured only while reset is held low. Execution starts at address 0 once reset is released.

Top module: `deci_acc_cpu`

## Requirements
- R1: While reset is low, `halted`, `out_valid` and `in_ready` are 0, and words written through the load port are stored. After reset is released, execution starts at address 0.
- R2: Instruction `d·100 + a` performs operation `d` on address `a`. Digits: 1 add, 2 subtract, 3 store, 5 load, 6 branch, 7 branch if zero, 8 branch if not negative. Words 000, 901 and 902 are halt, input and output.
- R3: Add sets the accumulator to (acc + mem[a]) mod 1000 and clears the negative flag.
- R4: Subtract sets the accumulator to acc − mem[a] when that difference is not below zero and clears the flag. Otherwise it stores acc + 1000 − mem[a] and sets the flag.
- R5: Store writes the accumulator to mem[a]. Load copies mem[a] into the accumulator and clears the flag.
- R6: Digit 6 always sets PC to `a`.
- R7: Digit 7 sets PC to `a` when the accumulator is 0. Otherwise PC advances.
- R8: Digit 8 sets PC to `a` when the negative flag is clear. Otherwise PC advances.
- R9: Word 901 raises `in_ready` only in its execute state. It stays there until `in_valid` is high, then loads `in_data` mod 1000 into the accumulator and clears the flag.
- R10: Word 902 raises `out_valid` for exactly one cycle, with `out_data` equal to the accumulator.
- R11: Word 000 moves the machine to a halted state after its fetch and decode. `halted` then stays 1 and no further input or output occurs.
- R12: Digit 4, and any 9xx word other than 901 and 902, changes only the PC, which advances by one.
- R13: Every non-halt instruction takes exactly five cycles plus any input wait, and a halt is reached three cycles after its fetch begins. PC advances from 99 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset; also enables the load port |
| ld_we | input | 1 | Load-port write enable (used only while rst_n is low) |
| ld_addr | input | 7 | Load-port word address |
| ld_data | input | 10 | Load-port word value (0 to 999) |
| in_valid | input | 1 | An input value is offered |
| in_data | input | 10 | Offered input value |
| in_ready | output | 1 | The machine is waiting to take an input value |
| out_valid | output | 1 | One-cycle strobe marking `out_data` |
| out_data | output | 10 | Value sent by an output instruction |
| halted | output | 1 | The machine has stopped |

## Verification
The assertions check properties that must hold on every cycle:
- PC and the accumulator stay in range.
- The two fetch states always follow one another.
- An input wait holds while no value is offered.
- `out_valid` lasts one cycle.
- The halted state is final and silent.
- Reset values apply.

Only the bench's programs can show the rest. These are the arithmetic results across the wrap and borrow corners, the branch decisions, store-then-load round trips, the no-op codes, the PC wrap, and the exact cycle count of each program.

// File: rtl/deci_pkg.sv
// Package: shared state encoding and opcode digits for the decimal
// accumulator processor. Assumes digits fit in 4 bits.
package deci_pkg;

    typedef enum logic [2:0] {
        ST_FADDR = 3'd0,
        ST_FDATA = 3'd1,
        ST_DEC   = 3'd2,
        ST_EXEC  = 3'd3,
        ST_WB    = 3'd4,
        ST_HALT  = 3'd5
    } cpu_state_e;

    localparam logic [3:0] OPC_ADD = 4'd1;
    localparam logic [3:0] OPC_SUB = 4'd2;
    localparam logic [3:0] OPC_STA = 4'd3;
    localparam logic [3:0] OPC_LDA = 4'd5;
    localparam logic [3:0] OPC_BRA = 4'd6;
    localparam logic [3:0] OPC_BRZ = 4'd7;
    localparam logic [3:0] OPC_BRP = 4'd8;

    localparam int WORD_IN  = 901;
    localparam int WORD_OUT = 902;

endpackage

// File: rtl/deci_mem.sv
// Module: word store with one synchronous write port and one
// combinational read port. Out-of-range addresses read 0 and drop writes.
module deci_mem #(
    parameter int WORDS = 100,
    parameter int DW    = 10,
    parameter int AW    = 7
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam logic [AW:0] LIM = (AW+1)'(WORDS);

    logic [DW-1:0] store [WORDS];

    // Write one word when enabled and in range.
    always_ff @(posedge clk) begin
        if (we && ({1'b0, waddr} < LIM)) store[waddr] <= wdata;
    end

    // Read the addressed word, or 0 when out of range.
    always_comb begin
        rdata = ({1'b0, raddr} < LIM) ? store[raddr] : '0;
    end
endmodule

// File: rtl/deci_dec.sv
// Module: splits an instruction word into its hundreds digit and its
// address field, and flags the reserved whole-word codes.
module deci_dec #(
    parameter int DW    = 10,
    parameter int AW    = 7,
    parameter int WORDS = 100
) (
    input  logic [DW-1:0] ir,
    output logic [3:0]    op,
    output logic [AW-1:0] addr,
    output logic          is_in,
    output logic          is_out,
    output logic          is_halt
);
    // Digit and field extraction plus reserved-word detection.
    always_comb begin
        op      = 4'(ir / DW'(WORDS));
        addr    = AW'(ir % DW'(WORDS));
        is_in   = (ir == DW'(deci_pkg::WORD_IN));
        is_out  = (ir == DW'(deci_pkg::WORD_OUT));
        is_halt = (ir == '0);
    end
endmodule

// File: rtl/deci_alu.sv
// Module: modulo adder and subtractor for the accumulator. Assumes both
// operands are already below MOD. neg reports a borrow on subtract.
module deci_alu #(
    parameter int DW  = 10,
    parameter int MOD = 1000
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sub,
    output logic [DW-1:0] y,
    output logic          neg
);
    localparam logic [DW:0] MODX = (DW+1)'(MOD);

    logic [DW:0] sum;
    logic [DW:0] wrapd;

    // Compute the wrapped sum or difference and the borrow.
    always_comb begin
        sum   = {1'b0, a} + {1'b0, b};
        wrapd = {1'b0, a} + MODX - {1'b0, b};
        if (sub) begin
            neg = (a < b);
            y   = neg ? DW'(wrapd) : (a - b);
        end else begin
            neg = 1'b0;
            y   = (sum >= MODX) ? DW'(sum - MODX) : DW'(sum);
        end
    end
endmodule

// File: rtl/deci_acc_cpu.sv
// Module: top of the decimal accumulator processor. A five-state
// sequencer (fetch address, fetch data, decode, execute, writeback) runs
// instructions from an internal store that is loaded only during reset.
// Assumes WORDS is also the decimal split between digit and address.
module deci_acc_cpu #(
    parameter int WORDS = 100,
    parameter int MOD   = 1000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ld_we,
    input  logic [$clog2(WORDS)-1:0] ld_addr,
    input  logic [$clog2(MOD)-1:0]   ld_data,
    input  logic                     in_valid,
    input  logic [$clog2(MOD)-1:0]   in_data,
    output logic                     in_ready,
    output logic                     out_valid,
    output logic [$clog2(MOD)-1:0]   out_data,
    output logic                     halted
);
    import deci_pkg::*;

    localparam int AW = $clog2(WORDS);
    localparam int DW = $clog2(MOD);
    localparam logic [AW-1:0] PC_LAST = AW'(WORDS - 1);

    cpu_state_e    state_q;
    logic [AW-1:0] pc_q, mar_q;
    logic [DW-1:0] mdr_q, ir_q, acc_q, out_q;
    logic          neg_q, outv_q;

    logic [3:0]    op;
    logic [AW-1:0] addr;
    logic          is_in, is_out, is_halt;
    logic [DW-1:0] mem_rd, alu_y;
    logic          alu_neg;
    logic          mem_we;
    logic [AW-1:0] mem_wa;
    logic [DW-1:0] mem_wd;
    logic [AW-1:0] pc_inc, pc_next;

    deci_mem #(.WORDS(WORDS), .DW(DW), .AW(AW)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_wa), .wdata(mem_wd),
        .raddr(mar_q), .rdata(mem_rd)
    );

    deci_dec #(.DW(DW), .AW(AW), .WORDS(WORDS)) u_dec (
        .ir(ir_q), .op(op), .addr(addr),
        .is_in(is_in), .is_out(is_out), .is_halt(is_halt)
    );

    deci_alu #(.DW(DW), .MOD(MOD)) u_alu (
        .a(acc_q), .b(mdr_q), .sub(op == OPC_SUB), .y(alu_y), .neg(alu_neg)
    );

    // Store write source: the load port during reset, otherwise a store.
    always_comb begin
        if (!rst_n) begin
            mem_we = ld_we;
            mem_wa = ld_addr;
            mem_wd = ld_data;
        end else begin
            mem_we = (state_q == ST_WB) && (op == OPC_STA);
            mem_wa = mar_q;
            mem_wd = mdr_q;
        end
    end

    // Next PC: a branch target when taken, otherwise the wrapped increment.
    always_comb begin
        pc_inc = (pc_q == PC_LAST) ? '0 : pc_q + 1'b1;
        unique case (op)
            OPC_BRA: pc_next = addr;
            OPC_BRZ: pc_next = (acc_q == '0) ? addr : pc_inc;
            OPC_BRP: pc_next = (!neg_q) ? addr : pc_inc;
            default: pc_next = pc_inc;
        endcase
    end

    // Sequencer and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FADDR;
            pc_q    <= '0;
            mar_q   <= '0;
            mdr_q   <= '0;
            ir_q    <= '0;
            acc_q   <= '0;
            neg_q   <= 1'b0;
            outv_q  <= 1'b0;
            out_q   <= '0;
        end else begin
            outv_q <= 1'b0;
            unique case (state_q)
                ST_FADDR: begin
                    mar_q   <= pc_q;
                    state_q <= ST_FDATA;
                end
                ST_FDATA: begin
                    mdr_q   <= mem_rd;
                    ir_q    <= mem_rd;
                    state_q <= ST_DEC;
                end
                ST_DEC: begin
                    if (is_halt) begin
                        state_q <= ST_HALT;
                    end else begin
                        mar_q   <= addr;
                        state_q <= ST_EXEC;
                    end
                end
                ST_EXEC: begin
                    state_q <= ST_WB;
                    if (is_in) begin
                        if (in_valid) begin
                            acc_q <= DW'(in_data % DW'(MOD));
                            neg_q <= 1'b0;
                        end else begin
                            state_q <= ST_EXEC;
                        end
                    end else if (is_out) begin
                        out_q  <= acc_q;
                        outv_q <= 1'b1;
                    end else if (op == OPC_STA) begin
                        mdr_q <= acc_q;
                    end else begin
                        mdr_q <= mem_rd;
                    end
                end
                ST_WB: begin
                    if (op == OPC_ADD || op == OPC_SUB) begin
                        acc_q <= alu_y;
                        neg_q <= alu_neg;
                    end else if (op == OPC_LDA) begin
                        acc_q <= mdr_q;
                        neg_q <= 1'b0;
                    end
                    pc_q    <= pc_next;
                    state_q <= ST_FADDR;
                end
                default: state_q <= ST_HALT;
            endcase
        end
    end

    assign in_ready  = (state_q == ST_EXEC) && is_in;
    assign out_valid = outv_q;
    assign out_data  = out_q;
    assign halted    = (state_q == ST_HALT);
endmodule

// File: rtl/deci_acc_chk.sv
// Module: property checker for the decimal accumulator processor,
// attached to every instance of the top through the bind below.
module deci_acc_chk #(
    parameter int WORDS = 100,
    parameter int MOD   = 1000,
    parameter int AW    = 7,
    parameter int DW    = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input deci_pkg::cpu_state_e state,
    input logic [AW-1:0]        pc,
    input logic [DW-1:0]        acc,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic                 out_valid,
    input logic                 halted
);
    import deci_pkg::*;

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!halted && !out_valid && !in_ready && pc == '0));

    p_acc_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        32'(acc) < MOD);

    p_wait_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> in_ready);

    p_out_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    p_halt_final_r11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    p_halt_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!in_ready && !out_valid));

    p_pc_range_r13: assert property (@(posedge clk) disable iff (!rst_n)
        32'(pc) < WORDS);

    p_fetch_step_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FADDR) |=> (state == ST_FDATA));

    p_fetch_dec_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FDATA) |=> (state == ST_DEC));
endmodule

bind deci_acc_cpu deci_acc_chk #(
    .WORDS(WORDS), .MOD(MOD), .AW($clog2(WORDS)), .DW($clog2(MOD))
) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state_q), .pc(pc_q), .acc(acc_q),
    .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid),
    .halted(halted)
);

// File: tb/sim_deci_acc_cpu.sv
// Bench: loads a program while reset is held, runs it to the halt, and
// compares the outputs and the cycle count with values computed here.
module sim_deci_acc_cpu;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ld_we = 1'b0;
    logic [6:0] ld_addr = '0;
    logic [9:0] ld_data = '0;
    logic       in_valid = 1'b0;
    logic [9:0] in_data = '0;
    logic       in_ready, out_valid, halted;
    logic [9:0] out_data;

    int n_chk = 0;
    int n_fail = 0;
    int img [100];
    int ins [4];
    int exp_out [8];
    string tg [8];
    int n_exp;
    int exp_cyc;

    deci_acc_cpu u0 (
        .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr),
        .ld_data(ld_data), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .halted(halted)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 100; i++) img[i] = 0;
        for (int i = 0; i < 4; i++) ins[i] = 0;
        n_exp = 0;
    endtask

    // Load the image under reset, release, and run until halted.
    task automatic run_prog(input int stall);
        int cyc, got, idx, left;
        bit take;
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        for (int i = 0; i < 100; i++) begin
            ld_we = 1'b1; ld_addr = 7'(i); ld_data = 10'(img[i]);
            @(negedge clk);
        end
        ld_we = 1'b0;
        chk("R1 halted in reset", int'(halted), 0);
        chk("R1 out_valid in reset", int'(out_valid), 0);
        chk("R1 in_ready in reset", int'(in_ready), 0);
        cyc = 0; got = 0; idx = 0; left = stall; take = 1'b0;
        in_data = 10'(ins[0]);
        rst_n = 1'b1;
        forever begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (take) begin
                if (idx < 3) idx++;
                in_data = 10'(ins[idx]);
            end
            if (in_ready && left > 0) begin
                left--;
                in_valid = 1'b0;
            end else begin
                in_valid = 1'b1;
            end
            take = in_ready && in_valid;
            if (out_valid) begin
                if (got < n_exp) chk(tg[got], int'(out_data), exp_out[got]);
                got++;
            end
            if (halted || cyc > 3000) break;
        end
        in_valid = 1'b0;
        chk("R11 halted reached", int'(halted), 1);
        chk("R10 output count", got, n_exp);
        chk("R13 cycles to halt", cyc, exp_cyc);
        // Stay halted: no output afterwards.
        repeat (3) begin
            @(negedge clk);
            chk("R11 silent after halt", int'(out_valid || in_ready || !halted), 0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int vals [8];
        vals = '{0, 1, 2, 499, 500, 501, 998, 999};

        // Arithmetic sweep: add, subtract with borrow, branch on sign (R3 R4 R8).
        foreach (vals[i]) foreach (vals[j]) begin
            int a, b;
            a = vals[i]; b = vals[j];
            clear_prog();
            img[0] = 901; img[1] = 120; img[2] = 902; img[3] = 901;
            img[4] = 220; img[5] = 902; img[6] = 809; img[7] = 521;
            img[8] = 610; img[9] = 522; img[10] = 902; img[11] = 0;
            img[20] = b; img[21] = 111; img[22] = 222;
            ins[0] = a; ins[1] = a;
            exp_out[0] = (a + b) % 1000;              tg[0] = "R3 add mod 1000";
            exp_out[1] = (a >= b) ? a - b : a + 1000 - b; tg[1] = "R4 subtract wrap";
            exp_out[2] = (a >= b) ? 222 : 111;        tg[2] = "R8 branch on sign";
            n_exp = 3;
            exp_cyc = (a >= b) ? 48 : 53;
            run_prog(0);
        end

        // Store, no-ops, load, branch on zero (R2 R5 R7 R12 R6).
        for (int v = 0; v < 1000; v += 37) begin
            int w;
            w = (v == 999 - 37 * 0) ? v : v;
            clear_prog();
            img[0] = 901; img[1] = 350; img[2] = 951; img[3] = 412;
            img[4] = 902; img[5] = 901; img[6] = 550; img[7] = 902;
            img[8] = 711; img[9] = 521; img[10] = 612; img[11] = 522;
            img[12] = 902; img[13] = 0; img[21] = 111; img[22] = 222;
            ins[0] = w; ins[1] = (w + 500) % 1000;
            exp_out[0] = w; tg[0] = "R12 no-op keeps acc";
            exp_out[1] = w; tg[1] = "R5 store then load";
            exp_out[2] = (w == 0) ? 222 : 111; tg[2] = "R7 branch on zero";
            n_exp = 3;
            exp_cyc = (w == 0) ? 58 : 63;
            run_prog(0);
        end

        // Input wait with and without stall (R9).
        for (int s = 0; s < 9; s += 7) begin
            clear_prog();
            img[0] = 901; img[1] = 902; img[2] = 0;
            ins[0] = 777;
            exp_out[0] = 777; tg[0] = "R9 input value";
            n_exp = 1;
            exp_cyc = 13 + s;
            run_prog(s);
        end

        // Add after a borrow clears the flag (R3 R8).
        clear_prog();
        img[0] = 901; img[1] = 220; img[2] = 120; img[3] = 805;
        img[4] = 0; img[5] = 902; img[6] = 0; img[20] = 5;
        ins[0] = 3;
        exp_out[0] = 3; tg[0] = "R3 add clears negative";
        n_exp = 1; exp_cyc = 28;
        run_prog(0);

        // PC advance from 99 to 0 and unconditional branch (R13 R6).
        clear_prog();
        img[0] = 901; img[1] = 703; img[2] = 698; img[3] = 0;
        img[98] = 902; img[99] = 412;
        ins[0] = 5; ins[1] = 0;
        exp_out[0] = 5; tg[0] = "R6 branch to 98";
        n_exp = 1; exp_cyc = 38;
        run_prog(0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule